// File: doc/BRIEF.md
# Unsigned Adder-Subtractor with Magnitude Output

This combinational unit adds or subtracts two unsigned operands of a configurable width, 4 bits by default. One mode input chooses the operation. For addition it returns the sum, the carry-out and an overflow flag. For subtraction it returns the size of the difference, `|A - B|`, and a separate flag that marks a negative difference. A consumer can then treat the result as a sign-and-magnitude value without any further arithmetic.

Inside, an XOR row inverts the B operand when subtracting. A shared ripple adder adds that to A, with the carry-in tied to the mode bit. A second adder-subtractor then computes `0 - S` from the raw sum S. This second stage is chosen only when the operation is a subtraction and the first adder gave no carry-out, which means B was larger than A. In every other case the raw sum passes through unchanged.

Top module: `usub_mag_addsub`

## Requirements
- R1: With `sub_i` = 0 (add), `res_o` equals (A + B) mod 2^W and `cout_o` is 1 exactly when A + B >= 2^W.
- R2: With `sub_i` = 0, `ovf_o` equals `cout_o`.
- R3: With `sub_i` = 0, `neg_o` is 0 for every operand pair.
- R4: With `sub_i` = 1 and A >= B, `res_o` equals A - B, `cout_o` is 1 and `neg_o` is 0.
- R5: With `sub_i` = 1 and B > A, `cout_o` is 0, `neg_o` is 1 and `res_o` equals B - A, which is the two's complement of the raw sum.
- R6: With `sub_i` = 1, `ovf_o` is 0 for every operand pair.
- R7: With `sub_i` = 1 and A equal to B, `res_o` is zero, `neg_o` is 0 and `cout_o` is 1.
- R8: At width 4, subtracting B = 4'b1011 from A = 4'b0011 gives `res_o` = 4'b1000 with `neg_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | Unsigned operand A (minuend when subtracting) |
| opb_i | input | W | Unsigned operand B (subtrahend when subtracting) |
| sub_i | input | 1 | Operation select: 0 adds, 1 subtracts |
| res_o | output | W | Sum, or magnitude of the difference |
| neg_o | output | 1 | Difference is negative (B > A while subtracting) |
| cout_o | output | 1 | Raw carry-out of the first adder |
| ovf_o | output | 1 | Unsigned overflow of an addition |

## Verification
A single subtraction can use both the borrow detection of the first adder and the complement stage at once. This happens whenever B exceeds A. In that case `cout_o` must drop, `neg_o` must rise, and `res_o` must show the corrected magnitude instead of the raw sum. The bench triggers this by sweeping every operand pair in both modes, so every borrowing pair is covered, including A = 0 with B at its maximum. For each pair it compares `res_o`, `neg_o`, `cout_o` and `ovf_o` with values it computes from integer arithmetic. The equal-operand and all-zero cases sit on the boundary where the complement stage must stay inactive, and they are checked by name.

// File: rtl/usub_mag_pkg.sv
package usub_mag_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/usub_mag_fa.sv
module usub_mag_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic hs;

    // Two half adders plus an OR.
    always_comb begin
        hs  = x_i ^ y_i;
        s_o = hs ^ c_i;
        c_o = (x_i & y_i) | (hs & c_i);
    end
endmodule

// File: rtl/usub_mag_core.sv
module usub_mag_core #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W-1:0] bx_d;
    logic [W:0]   cy_d;

    // XOR row acts as a programmable inverter on B.
    always_comb begin
        bx_d = b_i ^ {W{sub_i}};
    end

    assign cy_d[0] = sub_i;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            usub_mag_fa u_fa (
                .x_i (a_i[i]),
                .y_i (bx_d[i]),
                .c_i (cy_d[i]),
                .s_o (sum_o[i]),
                .c_o (cy_d[i+1])
            );
        end
    endgenerate

    assign cout_o = cy_d[W];
endmodule

// File: rtl/usub_mag_addsub.sv
module usub_mag_addsub
    import usub_mag_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         neg_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] ZERO_W = '0;

    typedef struct packed {
        logic [W-1:0] res;
        logic         neg;
        logic         cout;
        logic         ovf;
    } out_t;

    op_e          op_d;
    logic [W-1:0] raw_d;
    logic         rawc_d;
    logic [W-1:0] fix_d;
    logic         fixc_d;
    logic         fix_en_d;
    out_t         out_d;

    assign op_d = op_e'(sub_i);

    // First pass: A + B or A + ~B + 1.
    usub_mag_core #(.W(W)) u_main (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .sub_i  (sub_i),
        .sum_o  (raw_d),
        .cout_o (rawc_d)
    );

    // Second pass: 0 - raw, always in subtract mode.
    usub_mag_core #(.W(W)) u_fix (
        .a_i    (ZERO_W),
        .b_i    (raw_d),
        .sub_i  (1'b1),
        .sum_o  (fix_d),
        .cout_o (fixc_d)
    );

    always_comb begin
        fix_en_d  = (op_d == OP_SUB) && !rawc_d;
        out_d     = '0;
        out_d.res = fix_en_d ? fix_d : raw_d;
        out_d.neg = fix_en_d;
        out_d.cout = rawc_d;
        out_d.ovf = (op_d == OP_ADD) && rawc_d;
    end

    assign res_o  = out_d.res;
    assign neg_o  = out_d.neg;
    assign cout_o = out_d.cout;
    assign ovf_o  = out_d.ovf;

    // Carry of the correction pass is not needed.
    logic unused_fixc;
    assign unused_fixc = fixc_d;
endmodule

// File: rtl/usub_mag_addsub_chk.sv
module usub_mag_addsub_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic         sub_i,
    input logic [W-1:0] res_o,
    input logic         neg_o,
    input logic         cout_o,
    input logic         ovf_o
);
    always_comb begin
        AST_ADD_SUM: assert (sub_i || ({cout_o, res_o} == ({1'b0, opa_i} + {1'b0, opb_i})))
            else $error("add sum mismatch"); // R1
        AST_OVF_IS_CARRY: assert (sub_i || (ovf_o == cout_o))
            else $error("add overflow differs from carry"); // R2
        AST_ADD_NOT_NEG: assert (sub_i || !neg_o)
            else $error("negative flag during add"); // R3
        AST_SUB_POS: assert (!sub_i || (opa_i < opb_i) || (!neg_o && cout_o && (res_o == opa_i - opb_i)))
            else $error("non-negative difference wrong"); // R4
        AST_SUB_NEG: assert (!sub_i || (opa_i >= opb_i) || (neg_o && !cout_o && (res_o == opb_i - opa_i)))
            else $error("negative difference wrong"); // R5
        AST_NO_OVERFLOW: assert (!sub_i || !ovf_o)
            else $error("overflow during subtract"); // R6
        AST_EQ_ZERO: assert (!sub_i || (opa_i != opb_i) || (res_o == '0 && !neg_o))
            else $error("equal operands not zero"); // R7
    end
endmodule

bind usub_mag_addsub usub_mag_addsub_chk #(.W(W)) u_chk (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .sub_i  (sub_i),
    .res_o  (res_o),
    .neg_o  (neg_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/usub_mag_addsub_bench.sv
module usub_mag_addsub_bench;
    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic         sub;
    logic [W-1:0] res;
    logic         neg, cout, ovf;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    usub_mag_addsub #(.W(W)) u_usub_mag_addsub (
        .opa_i  (a),
        .opb_i  (b),
        .sub_i  (sub),
        .res_o  (res),
        .neg_o  (neg),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d", req, a, b, sub, act, exp);
        end
    endtask

    task automatic apply(input int av, input int bv, input bit s);
        @(posedge clk);
        a   = W'(av);
        b   = W'(bv);
        sub = s;
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Quiet state with zero inputs.
        apply(0, 0, 1'b0);
        chk("R1 idle res", res, 0);
        chk("R2 idle ovf", ovf, 0);
        chk("R3 idle neg", neg, 0);

        // Exhaustive add sweep.
        for (int i = 0; i <= MAXV; i++) begin
            for (int j = 0; j <= MAXV; j++) begin
                apply(i, j, 1'b0);
                chk("R1 sum", res, (i + j) % (MAXV + 1));
                chk("R1 carry", cout, (i + j > MAXV) ? 1 : 0);
                chk("R2 ovf", ovf, (i + j > MAXV) ? 1 : 0);
                chk("R3 neg", neg, 0);
            end
        end

        // Exhaustive subtract sweep.
        for (int i = 0; i <= MAXV; i++) begin
            for (int j = 0; j <= MAXV; j++) begin
                apply(i, j, 1'b1);
                if (i >= j) begin
                    chk("R4 res", res, i - j);
                    chk("R4 carry", cout, 1);
                    chk("R4 neg", neg, 0);
                end else begin
                    chk("R5 res", res, j - i);
                    chk("R5 carry", cout, 0);
                    chk("R5 neg", neg, 1);
                end
                chk("R6 ovf", ovf, 0);
            end
        end

        // Named corners.
        apply(5, 5, 1'b1);
        chk("R7 res", res, 0);
        chk("R7 neg", neg, 0);
        chk("R7 carry", cout, 1);
        apply(0, 0, 1'b1);
        chk("R7 zero res", res, 0);
        chk("R7 zero carry", cout, 1);
        apply(3, 11, 1'b1);
        chk("R8 res", res, 8);
        chk("R8 neg", neg, 1);
        apply(0, MAXV, 1'b1);
        chk("R5 max res", res, MAXV);
        chk("R5 max neg", neg, 1);
        apply(MAXV, MAXV, 1'b0);
        chk("R2 max ovf", ovf, 1);
        chk("R1 max res", res, MAXV - 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule